// File: doc/BRIEF.md
# Configuration Memory Access Guard

This block sits in front of a small configuration store. It decides whether each access request may proceed, based on two lock bits it holds. The read lock hides the stored pattern and also freezes it. The write lock guards the pattern against accidental programming or erasure. The two bits together give four security settings: open, write-locked, read-locked, and both locked.

A requester presents one operation per cycle: an opcode, a word address and write data, qualified by a valid strobe. Exactly one cycle later the block answers with a response strobe, a grant flag and, for a granted read, the stored word. A refused request changes nothing.

A full erase fills the store with ones and removes the read lock. Nothing else can remove the read lock. The write lock is removed by an explicit command. The store is a register array, so the whole erase completes in the same cycle as a program would.

Top module: `cfg_guard`

## Requirements
- R1: After reset both lock bits are clear, every stored word reads as all ones, and rsp_valid is low.
- R2: Each cycle with req_valid high produces rsp_valid high in the following cycle. A cycle with req_valid low produces rsp_valid low in the following cycle.
- R3: Opcode encoding on req_op: 0 read, 1 program, 2 full erase, 3 set read lock, 4 set write lock, 5 clear write lock. Codes 6 and 7 are refused and change nothing.
- R4: A granted read returns the word at req_addr on rsp_data. A refused response always carries rsp_data equal to zero.
- R5: With both locks clear, a program request is granted and replaces the word at req_addr with req_data.
- R6: While the read lock is set, read and program requests are refused and the store is unchanged.
- R7: While the write lock is set, program and full-erase requests are refused, even if the read lock is also set. The store and both lock bits stay unchanged.
- R8: A full erase with the write lock clear is granted. It sets every word to all ones, clears the read lock and leaves the write lock as it was.
- R9: The read lock is cleared only by a granted full erase. In particular, clearing the write lock leaves the read lock set.
- R10: The three lock commands are always granted. Once the write lock has been cleared, program and erase are accepted again, subject to the read lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (see R3) |
| req_addr | input | ADDR_W | Word address for read and program |
| req_data | input | DATA_W | Data for program |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_grant | output | 1 | 1 = operation performed, 0 = refused |
| rsp_data | output | DATA_W | Read word on a granted read, else zero |

## Verification
The bench steers the two lock bits through all four settings and tests each operation in each of them. Several corner cases get targeted checks:
- An erase attempted while both locks are set must be refused. A design that let the read lock override the write lock would wipe the store and unlock it.
- After the write lock is cleared, the read lock must still hide data. A design that tied the two clears together would leak the pattern.
- A refused read must return zero rather than the stored word. A refused program must leave the old word intact, which the bench confirms by a later readback.
- Unused opcodes must be refused without side effects.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

  typedef logic [2:0] op_t;

  localparam op_t OP_READ      = 3'd0;
  localparam op_t OP_PROG      = 3'd1;
  localparam op_t OP_ERASE     = 3'd2;
  localparam op_t OP_LOCK_RD   = 3'd3;
  localparam op_t OP_LOCK_WR   = 3'd4;
  localparam op_t OP_UNLOCK_WR = 3'd5;

  typedef struct packed {
    logic rd_lock;
    logic wr_lock;
  } prot_t;

  // Access policy: whether an operation is allowed in a given lock state.
  function automatic logic op_permitted(input op_t op, input prot_t p);
    logic ok;
    case (op)
      OP_READ:      ok = !p.rd_lock;
      OP_PROG:      ok = !p.rd_lock && !p.wr_lock;
      OP_ERASE:     ok = !p.wr_lock;
      OP_LOCK_RD,
      OP_LOCK_WR,
      OP_UNLOCK_WR: ok = 1'b1;
      default:      ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Next lock state after a granted operation.
  function automatic prot_t prot_next(input op_t op, input prot_t p);
    prot_t n;
    n = p;
    case (op)
      OP_ERASE:     n.rd_lock = 1'b0;
      OP_LOCK_RD:   n.rd_lock = 1'b1;
      OP_LOCK_WR:   n.wr_lock = 1'b1;
      OP_UNLOCK_WR: n.wr_lock = 1'b0;
      default:      n = p;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/cfg_guard_policy.sv
module cfg_guard_policy
  import cfg_guard_pkg::*;
(
  input  logic  req_valid,
  input  op_t   req_op,
  input  prot_t prot,
  output logic  grant,
  output logic  do_read,
  output logic  do_prog,
  output logic  do_erase,
  output logic  do_lock
);

  logic allowed;

  always_comb begin
    allowed  = op_permitted(req_op, prot);
    grant    = req_valid && allowed;
    do_read  = grant && (req_op == OP_READ);
    do_prog  = grant && (req_op == OP_PROG);
    do_erase = grant && (req_op == OP_ERASE);
    do_lock  = grant && ((req_op == OP_LOCK_RD) || (req_op == OP_LOCK_WR) ||
                         (req_op == OP_UNLOCK_WR));
  end

endmodule

// File: rtl/cfg_guard_prot.sv
module cfg_guard_prot
  import cfg_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_en,
  input  op_t   upd_op,
  output prot_t prot_q
);

  prot_t prot_d;

  always_comb begin
    prot_d = upd_en ? prot_next(upd_op, prot_q) : prot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0;
    end else begin
      prot_q <= prot_d;
    end
  end

endmodule

// File: rtl/cfg_guard_array.sv
module cfg_guard_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clr_all,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[i] <= BLANK;
      end else if (clr_all) begin
        words[i] <= BLANK;
      end else if (hit) begin
        words[i] <= wr_data;
      end
    end
  end

  assign rd_data = words[addr];

endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic [DATA_W-1:0] rsp_data
);

  prot_t             prot_q;
  logic              grant;
  logic              do_read;
  logic              do_prog;
  logic              do_erase;
  logic              do_lock;
  logic              prot_upd;
  logic [DATA_W-1:0] mem_rd;

  cfg_guard_policy u_policy (
    .req_valid (req_valid),
    .req_op    (req_op),
    .prot      (prot_q),
    .grant     (grant),
    .do_read   (do_read),
    .do_prog   (do_prog),
    .do_erase  (do_erase),
    .do_lock   (do_lock)
  );

  assign prot_upd = do_lock || do_erase;

  cfg_guard_prot u_prot (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (prot_upd),
    .upd_op (req_op),
    .prot_q (prot_q)
  );

  cfg_guard_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (do_prog),
    .clr_all (do_erase),
    .addr    (req_addr),
    .wr_data (req_data),
    .rd_data (mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= grant;
      rsp_data  <= do_read ? mem_rd : '0;
    end
  end

endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk
  import cfg_guard_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic              rsp_valid,
  input logic              rsp_grant,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rd_lock,
  input logic              wr_lock,
  input logic              do_erase
);

  // R2: response strobe follows request strobe by one cycle
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R4: refused responses carry zero data
  p_deny_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> (rsp_data == '0));

  // R6: read lock refuses read and program
  p_rdlock_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rd_lock && (req_op == OP_READ)) |=> !rsp_grant);
  p_rdlock_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rd_lock && (req_op == OP_PROG)) |=> !rsp_grant);

  // R7: write lock refuses program and erase, and keeps the read lock
  p_wrlock_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wr_lock && (req_op == OP_ERASE)) |=> (!rsp_grant && $stable(rd_lock)));
  p_wrlock_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wr_lock && (req_op == OP_PROG)) |=> !rsp_grant);

  // R8: erase leaves the write lock alone and removes the read lock
  p_erase_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    do_erase |=> (!rd_lock && $stable(wr_lock)));

  // R9: read lock falls only after a granted erase
  p_rdlock_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_lock) |-> $past(do_erase));

  // R3: unused opcodes are refused
  p_bad_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op > OP_UNLOCK_WR)) |=> (rsp_valid && !rsp_grant));

  // R10: lock commands are always granted
  p_lock_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op >= OP_LOCK_RD) && (req_op <= OP_UNLOCK_WR)) |=> rsp_grant);

endmodule

bind cfg_guard cfg_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .rsp_valid (rsp_valid),
  .rsp_grant (rsp_grant),
  .rsp_data  (rsp_data),
  .rd_lock   (prot_q.rd_lock),
  .wr_lock   (prot_q.wr_lock),
  .do_erase  (do_erase)
);

// File: tb/cfg_guard_test.sv
`timescale 1ns/1ps
module cfg_guard_test;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam logic [DW-1:0] ONES = 16'hFFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          rsp_valid;
  logic          rsp_grant;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_guard #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_data  (rsp_data)
  );

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request at a falling edge; sample its response a cycle later.
  task automatic issue(input string tag, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic exp_grant, input logic [DW-1:0] exp_data);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    expect_eq({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    expect_eq({tag, " grant"}, {31'd0, rsp_grant}, {31'd0, exp_grant});
    expect_eq({tag, " data"}, {16'd0, rsp_data}, {16'd0, exp_data});
  endtask

  task automatic t_reset;
    expect_eq("R1 rsp_valid low in reset", {31'd0, rsp_valid}, 32'd0);
    issue("R1 read word0 blank", 3'd0, 4'd0, 16'h0, 1'b1, ONES);
    issue("R1 read word15 blank", 3'd0, 4'd15, 16'h0, 1'b1, ONES);
    @(negedge clk);
    expect_eq("R2 no response when idle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_program;
    issue("R5 program w3", 3'd1, 4'd3, 16'h1234, 1'b1, 16'h0);
    issue("R5 program w7", 3'd1, 4'd7, 16'hABCD, 1'b1, 16'h0);
    issue("R4 readback w3", 3'd0, 4'd3, 16'h0, 1'b1, 16'h1234);
    issue("R4 readback w7", 3'd0, 4'd7, 16'h0, 1'b1, 16'hABCD);
    issue("R4 neighbour w4 blank", 3'd0, 4'd4, 16'h0, 1'b1, ONES);
  endtask

  task automatic t_bad_ops;
    issue("R3 opcode 6 refused", 3'd6, 4'd3, 16'h0000, 1'b0, 16'h0);
    issue("R3 opcode 7 refused", 3'd7, 4'd3, 16'h0000, 1'b0, 16'h0);
    issue("R3 w3 untouched", 3'd0, 4'd3, 16'h0, 1'b1, 16'h1234);
  endtask

  task automatic t_read_lock;
    issue("R10 set read lock", 3'd3, 4'd0, 16'h0, 1'b1, 16'h0);
    issue("R6 read refused zero", 3'd0, 4'd3, 16'h0, 1'b0, 16'h0);
    issue("R6 program refused", 3'd1, 4'd3, 16'h5555, 1'b0, 16'h0);
    issue("R9 clear write lock granted", 3'd5, 4'd0, 16'h0, 1'b1, 16'h0);
    issue("R9 read still locked", 3'd0, 4'd7, 16'h0, 1'b0, 16'h0);
  endtask

  task automatic t_both_locks;
    issue("R10 set write lock", 3'd4, 4'd0, 16'h0, 1'b1, 16'h0);
    issue("R7 erase refused under both", 3'd2, 4'd0, 16'h0, 1'b0, 16'h0);
    issue("R7 read lock kept", 3'd0, 4'd3, 16'h0, 1'b0, 16'h0);
    issue("R10 clear write lock", 3'd5, 4'd0, 16'h0, 1'b1, 16'h0);
    issue("R8 erase granted", 3'd2, 4'd0, 16'h0, 1'b1, 16'h0);
    issue("R8 w3 erased, read lock gone", 3'd0, 4'd3, 16'h0, 1'b1, ONES);
    issue("R8 w7 erased", 3'd0, 4'd7, 16'h0, 1'b1, ONES);
  endtask

  task automatic t_write_lock;
    issue("R5 program w5", 3'd1, 4'd5, 16'h0F0F, 1'b1, 16'h0);
    issue("R10 set write lock", 3'd4, 4'd0, 16'h0, 1'b1, 16'h0);
    issue("R7 program refused", 3'd1, 4'd5, 16'h1111, 1'b0, 16'h0);
    issue("R7 erase refused", 3'd2, 4'd0, 16'h0, 1'b0, 16'h0);
    issue("R7 read allowed, w5 kept", 3'd0, 4'd5, 16'h0, 1'b1, 16'h0F0F);
    issue("R10 clear write lock", 3'd5, 4'd0, 16'h0, 1'b1, 16'h0);
    issue("R10 program accepted again", 3'd1, 4'd5, 16'h2222, 1'b1, 16'h0);
    issue("R10 w5 updated", 3'd0, 4'd5, 16'h0, 1'b1, 16'h2222);
    issue("R8 erase with wr lock clear", 3'd2, 4'd0, 16'h0, 1'b1, 16'h0);
    issue("R8 w5 blank", 3'd0, 4'd5, 16'h0, 1'b1, ONES);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre: begin
      expect_eq("R1 rsp_valid low under reset", {31'd0, rsp_valid}, 32'd0);
    end
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_bad_ops();
    t_read_lock();
    t_both_locks();
    t_write_lock();
    @(negedge clk);
    expect_eq("R2 idle after last request", {31'd0, rsp_valid}, 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule